// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a 48-bit virtual address into a physical address. It does this by walking a four-level radix page table that sits in memory. A client hands it a translation request made of a virtual address and an address-space tag. The client also supplies the physical base of the top-level table. The walker then reads one 64-bit entry per level through a valid/ready memory port, and the memory may take any number of cycles to answer. Each entry it reads either points to the next table down or ends the walk.

A walk ends in one of two ways. It can reach a leaf, and the block then returns the physical address, the frame number, the write and user permission bits, and a flag for a 2 MB mapping. Or it can meet an entry that is not present, and the block then returns a fault. The fault carries the virtual address and the level at which the walk stopped.

Only one walk runs at a time, and only one memory read is ever in flight. The request port stays closed from the moment a walk is accepted until its result has been taken.

Top module: `rw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0.
- R2: The read for level L (L = 0 top to 3 bottom) goes to table base + index × 8. The index comes from virtual-address bits 47:39, 38:30, 29:21 and 20:12 for L = 0, 1, 2 and 3, and the levels are read in that order. The level-0 table base is `root_base` bits 51:12, with its low 12 bits taken as zero.
- R3: In every entry, bit 0 is present. Bits 51:12 of a present non-leaf entry give the base of the next table, and bits 63:52 are ignored.
- R4: A 4 KB leaf (level 3) sets `rsp_paddr` = entry[51:12] << 12 | vaddr[11:0] and `rsp_frame` = `rsp_paddr`[51:12]. For example, vaddr 0x008080604123 has indices 1, 2, 3 and 4, and a leaf frame of 0x1F2A3 gives 0x1F2A3123.
- R5: A present level-2 entry with bit 7 set ends the walk after three reads. It sets `rsp_huge` = 1 and `rsp_paddr` = entry[51:21] << 21 | vaddr[20:0]. Bit 7 in a level-0 or level-1 entry is ignored.
- R6: An entry with bit 0 = 0 at any level ends the walk and issues no further reads. The response then has `rsp_fault` = 1, `rsp_level` = that level, `rsp_vaddr` = the requested address, and `rsp_paddr` = 0.
- R7: `rsp_writable` and `rsp_user` copy bits 1 and 2 of the leaf entry.
- R8: At most one memory read is outstanding. A read request holds its address steady until it is accepted.
- R9: `req_ready` stays 0 from the acceptance of a request until its response is accepted, and any request offered in that time is ignored. The response holds steady while `rsp_ready` is 0.
- R10: `rsp_asid` returns the tag that came with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_asid | input | 16 | Address-space tag |
| root_base | input | 52 | Physical base of the top-level table |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Walk stopped on a non-present entry |
| rsp_level | output | 2 | Level at which the walk ended |
| rsp_vaddr | output | 48 | Virtual address of the walk |
| rsp_asid | output | 16 | Tag of the walk |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_frame | output | 40 | Physical frame number of the result |
| rsp_writable | output | 1 | Leaf write permission |
| rsp_user | output | 1 | Leaf user permission |
| rsp_huge | output | 1 | Result comes from a 2 MB mapping |

## Verification
Some properties are checked by assertions on every cycle:
- entry reads are 8-byte aligned and there is never more than one in flight;
- a stalled read or a stalled response holds its values;
- the request port stays closed while a walk is busy;
- the offset bits pass through;
- a fault is reported after exactly as many reads as its level plus one.

Other behaviour can only be shown by the bench scenarios with a table model:
- that each read lands on the right index within the right table;
- that the frame, the permission bits and the huge-page bits come out correctly;
- that bit 7 is ignored above level 2;
- that an offer made during a busy walk is dropped;
- that a reset in the middle of a walk returns the block to idle.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int unsigned ENTRY_W     = 64;
  localparam int unsigned ENT_BYTES_W = 3;
  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned WRITE_BIT   = 1;
  localparam int unsigned USER_BIT    = 2;
  localparam int unsigned LARGE_BIT   = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/rw_rst_sync.sv
module rw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rw_index_sel.sv
module rw_index_sel #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W  = $clog2(LEVELS),
  localparam int unsigned BASE_W = PA_W - OFF_W
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [LVL_W-1:0]  level,
  input  logic [BASE_W-1:0] table_base,
  output logic [PA_W-1:0]   rd_addr
);
  import rw_pkg::*;

  logic [IDX_W-1:0] idx_by_lvl [LEVELS];
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  base_addr;
  logic [PA_W-1:0]  ent_off;

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign idx_by_lvl[l] = vaddr[OFF_W + IDX_W*(LEVELS-1-l) +: IDX_W];
  end

  always_comb begin
    idx       = idx_by_lvl[level];
    base_addr = {table_base, {OFF_W{1'b0}}};
    ent_off   = '0;
    ent_off[IDX_W+ENT_BYTES_W-1:0] = {idx, {ENT_BYTES_W{1'b0}}};
    rd_addr   = base_addr + ent_off;
  end
endmodule

// File: rtl/rw_entry_dec.sv
module rw_entry_dec #(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned PA_W       = 52,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned HUGE_LEVEL = 2,
  localparam int unsigned LVL_W      = $clog2(LEVELS),
  localparam int unsigned BASE_W     = PA_W - OFF_W,
  localparam int unsigned HUGE_OFF_W = OFF_W + IDX_W*(LEVELS-1-HUGE_LEVEL)
) (
  input  logic [rw_pkg::ENTRY_W-1:0] entry,
  input  logic [LVL_W-1:0]           level,
  input  logic [VA_W-1:0]            vaddr,
  output logic                       present,
  output logic                       terminal,
  output logic                       huge,
  output logic                       writable,
  output logic                       user,
  output logic [BASE_W-1:0]          next_base,
  output logic [PA_W-1:0]            leaf_paddr
);
  import rw_pkg::*;

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam logic [LVL_W-1:0] HUGE_LVL = LVL_W'(HUGE_LEVEL);

  always_comb begin
    present   = entry[PRESENT_BIT];
    writable  = entry[WRITE_BIT];
    user      = entry[USER_BIT];
    next_base = entry[PA_W-1:OFF_W];
    huge      = (level == HUGE_LVL) && entry[LARGE_BIT];
    terminal  = (level == LAST_LVL) || huge;
    if (huge) leaf_paddr = {entry[PA_W-1:HUGE_OFF_W], vaddr[HUGE_OFF_W-1:0]};
    else      leaf_paddr = {entry[PA_W-1:OFF_W], vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/rw_ctrl.sv
module rw_ctrl #(
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             rsp_ready,
  input  logic             ent_present,
  input  logic             ent_terminal,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic             mem_rsp_ready,
  output logic             rsp_valid,
  output logic             accept,
  output logic             advance,
  output logic             finish,
  output logic [LVL_W-1:0] level
);
  import rw_pkg::*;

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             level_en;
  logic             ent_in;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_ISSUE);
    mem_rsp_ready = (state_q == ST_WAIT);
    rsp_valid     = (state_q == ST_DONE);
    ent_in        = mem_rsp_ready && mem_rsp_valid;
    accept        = req_ready && req_valid;
    advance       = ent_in && ent_present && !ent_terminal;
    finish        = ent_in && (!ent_present || ent_terminal);
  end

  always_comb begin
    state_d  = state_q;
    level_d  = level_q;
    level_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_ISSUE;
        level_d  = '0;
        level_en = 1'b1;
      end
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (advance) begin
          state_d  = ST_ISSUE;
          level_d  = level_q + 1'b1;
          level_en = 1'b1;
        end else if (finish) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: if (rsp_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= '0;
    else if (level_en) level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/rw_walker.sv
module rw_walker #(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned PA_W       = 52,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned HUGE_LEVEL = 2,
  parameter int unsigned ASID_W     = 16,
  localparam int unsigned LVL_W     = $clog2(LEVELS),
  localparam int unsigned BASE_W    = PA_W - OFF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [ASID_W-1:0]          req_asid,
  input  logic [PA_W-1:0]            root_base,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [PA_W-1:0]            mem_req_addr,
  input  logic                       mem_rsp_valid,
  output logic                       mem_rsp_ready,
  input  logic [rw_pkg::ENTRY_W-1:0] mem_rsp_data,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_fault,
  output logic [LVL_W-1:0]           rsp_level,
  output logic [VA_W-1:0]            rsp_vaddr,
  output logic [ASID_W-1:0]          rsp_asid,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic [BASE_W-1:0]          rsp_frame,
  output logic                       rsp_writable,
  output logic                       rsp_user,
  output logic                       rsp_huge
);
  logic              rst_n_s;
  logic              accept, advance, finish;
  logic [LVL_W-1:0]  level;
  logic              ent_present, ent_terminal, ent_huge, ent_w, ent_u;
  logic [BASE_W-1:0] ent_next_base;
  logic [PA_W-1:0]   ent_leaf_paddr;

  logic [VA_W-1:0]   vaddr_q;
  logic [ASID_W-1:0] asid_q;
  logic [BASE_W-1:0] base_q, base_d;
  logic              base_en;
  logic              fault_q, w_q, u_q, huge_q;
  logic              fault_d, w_d, u_d, huge_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;

  rw_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rw_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_ready     (rsp_ready),
    .ent_present   (ent_present),
    .ent_terminal  (ent_terminal),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .rsp_valid     (rsp_valid),
    .accept        (accept),
    .advance       (advance),
    .finish        (finish),
    .level         (level)
  );

  rw_index_sel #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_index_sel (
    .vaddr      (vaddr_q),
    .level      (level),
    .table_base (base_q),
    .rd_addr    (mem_req_addr)
  );

  rw_entry_dec #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .HUGE_LEVEL(HUGE_LEVEL)
  ) u_entry_dec (
    .entry      (mem_rsp_data),
    .level      (level),
    .vaddr      (vaddr_q),
    .present    (ent_present),
    .terminal   (ent_terminal),
    .huge       (ent_huge),
    .writable   (ent_w),
    .user       (ent_u),
    .next_base  (ent_next_base),
    .leaf_paddr (ent_leaf_paddr)
  );

  // next-state of the datapath registers
  always_comb begin
    base_en = accept || advance;
    base_d  = accept ? root_base[PA_W-1:OFF_W] : ent_next_base;
    fault_d = !ent_present;
    paddr_d = ent_present ? ent_leaf_paddr : '0;
    w_d     = ent_present && ent_w;
    u_d     = ent_present && ent_u;
    huge_d  = ent_present && ent_huge;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vaddr_q <= '0;
      asid_q  <= '0;
    end else if (accept) begin
      vaddr_q <= req_vaddr;
      asid_q  <= req_asid;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fault_q <= 1'b0;
      paddr_q <= '0;
      w_q     <= 1'b0;
      u_q     <= 1'b0;
      huge_q  <= 1'b0;
    end else if (finish) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
      w_q     <= w_d;
      u_q     <= u_d;
      huge_q  <= huge_d;
    end
  end

  assign rsp_fault    = fault_q;
  assign rsp_level    = level;
  assign rsp_vaddr    = vaddr_q;
  assign rsp_asid     = asid_q;
  assign rsp_paddr    = paddr_q;
  assign rsp_frame    = paddr_q[PA_W-1:OFF_W];
  assign rsp_writable = w_q;
  assign rsp_user     = u_q;
  assign rsp_huge     = huge_q;
endmodule

// File: rtl/rw_walker_chk.sv
module rw_walker_chk #(
  parameter int unsigned VA_W       = 48,
  parameter int unsigned PA_W       = 52,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned LEVELS     = 4,
  parameter int unsigned HUGE_LEVEL = 2,
  localparam int unsigned LVL_W      = $clog2(LEVELS),
  localparam int unsigned HUGE_OFF_W = OFF_W + IDX_W*(LEVELS-1-HUGE_LEVEL),
  localparam int unsigned CNT_W      = $clog2(LEVELS+2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [LVL_W-1:0] rsp_level,
  input logic [VA_W-1:0]  rsp_vaddr,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_huge
);
  logic             pending_q;
  logic [CNT_W-1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pending_q <= 1'b1;
    else if (mem_rsp_valid && mem_rsp_ready) pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reads_q <= '0;
    else if (req_valid && req_ready) reads_q <= '0;
    else if (mem_req_valid && mem_req_ready) reads_q <= reads_q + 1'b1;
  end

  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  a_r4_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);

  a_r5_huge_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_huge) |->
      (!rsp_fault && rsp_paddr[HUGE_OFF_W-1:0] == rsp_vaddr[HUGE_OFF_W-1:0]));

  a_r6_fault_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |->
      (reads_q == CNT_W'(rsp_level) + 1'b1 && rsp_paddr == '0));

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !mem_req_valid);

  a_r8_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= CNT_W'(LEVELS));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r9_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q || rsp_valid || mem_req_valid) |-> !req_ready);

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_level)));
endmodule

bind rw_walker rw_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
  .LEVELS(LEVELS), .HUGE_LEVEL(HUGE_LEVEL)
) u_rw_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_level     (rsp_level),
  .rsp_vaddr     (rsp_vaddr),
  .rsp_paddr     (rsp_paddr),
  .rsp_huge      (rsp_huge)
);

// File: tb/rw_walker_bench.sv
`timescale 1ns/1ps
module rw_walker_bench;
  typedef struct packed {
    logic [47:0] va;
    logic [15:0] asid;
    logic [51:0] root;
    logic [63:0] e0;
    logic [63:0] e1;
    logic [63:0] e2;
    logic [63:0] e3;
    logic [3:0]  stall;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{48'h0080_8060_4123, 16'h0011, 52'h0_0000_0000_1000, 64'h2001, 64'h3001, 64'h4001,
      64'h1F2A_3007, 4'd0, 4'd0},
    '{48'h3A5C_1D2E_3F47, 16'h0ABC, 52'h0_0000_0000_8000, 64'h1_0001, 64'h1_1003,
      64'h3_4560_0083, 64'hDEAD_BEEF, 4'd2, 4'd3},
    '{48'h1234_5678_9ABC, 16'h0003, 52'h0_0000_0002_0000, 64'h0000_000F_FFFF_F0FE, 64'h0,
      64'h0, 64'h0, 4'd1, 4'd1},
    '{48'h7F00_0010_0FFF, 16'h0004, 52'h0_0000_0000_3000, 64'h5001, 64'h6007,
      64'h0007_0086, 64'h0, 4'd0, 4'd5},
    '{48'h0000_0000_0FFF, 16'h0005, 52'h0_0000_0000_9000, 64'hA001, 64'hB001, 64'hC001,
      64'h0001_2345_6006, 4'd3, 4'd0},
    '{48'h0040_2010_0804, 16'h0006, 52'h0_0000_0000_D000, 64'hE081, 64'hF081, 64'h1_0001,
      64'h00AB_CDEF_0003, 4'd1, 4'd2},
    '{48'h8000_0000_0000, 16'hFFFF, 52'hF_FFFF_FFFF_F000, 64'hFFF0_0000_0020_0001,
      64'h8000_0000_0030_0001, 64'h0040_0005, 64'hFFFF_FFFF_FFFF_F001, 4'd0, 4'd0},
    '{48'hFFFF_FFFF_FFFF, 16'h1357, 52'h0_0000_0500_0ABC, 64'h7_1001, 64'h7_2001,
      64'h7FE0_0087, 64'h0, 4'd2, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [47:0] req_vaddr;
  logic [15:0] req_asid;
  logic [51:0] root_base;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_vaddr;
  logic [15:0] rsp_asid;
  logic [51:0] rsp_paddr;
  logic [39:0] rsp_frame;
  logic        rsp_writable, rsp_user, rsp_huge;

  int n_chk  = 0;
  int n_fail = 0;
  logic [51:0] last_paddr;
  logic [39:0] last_frame;

  always #2 clk = ~clk;

  rw_walker u_rw_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_asid(req_asid), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_vaddr(rsp_vaddr), .rsp_asid(rsp_asid),
    .rsp_paddr(rsp_paddr), .rsp_frame(rsp_frame), .rsp_writable(rsp_writable),
    .rsp_user(rsp_user), .rsp_huge(rsp_huge)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ent_of(input vec_t v, input int k);
    case (k)
      0: return v.e0;
      1: return v.e1;
      2: return v.e2;
      default: return v.e3;
    endcase
  endfunction

  // R2/R3: expected read address for level k
  function automatic logic [51:0] exp_addr(input vec_t v, input int k);
    logic [51:0] base;
    logic [8:0]  idx;
    base = (k == 0) ? {v.root[51:12], 12'h000} : {ent_of(v, k-1)[51:12], 12'h000};
    idx  = v.va[47-9*k -: 9];
    return base + {40'h0, idx, 3'b000};
  endfunction

  task automatic exp_walk(input vec_t v, output logic fault, output int lvl, output int nrd,
                          output logic [51:0] pa, output logic w, output logic u,
                          output logic hg);
    fault = 1'b0; lvl = 0; nrd = 0; pa = '0; w = 1'b0; u = 1'b0; hg = 1'b0;
    for (int l = 0; l < 4; l++) begin
      logic [63:0] e;
      e = ent_of(v, l);
      nrd = l + 1;
      lvl = l;
      if (!e[0]) begin
        fault = 1'b1;
        return;
      end
      if (l == 3 || (l == 2 && e[7])) begin
        hg = (l == 2);
        w  = e[1];
        u  = e[2];
        pa = hg ? {e[51:21], v.va[20:0]} : {e[51:12], v.va[11:0]};
        return;
      end
    end
  endtask

  task automatic run_vec(input int vi, input bit poke);
    vec_t        v;
    logic        e_fault, e_w, e_u, e_hg;
    int          e_lvl, e_nrd, nrd;
    logic [51:0] e_pa;
    logic [51:0] held;
    v = VECS[vi];
    exp_walk(v, e_fault, e_lvl, e_nrd, e_pa, e_w, e_u, e_hg);
    nrd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_asid = v.asid; root_base = v.root;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = '0; req_asid = '0; root_base = '0;
    chk("R9 req_ready low after accept", {63'h0, req_ready}, 64'h0);
    forever begin
      if (rsp_valid) break;
      if (mem_req_valid) begin
        chk($sformatf("R2 R3 read addr v%0d lvl%0d", vi, nrd), {12'h0, mem_req_addr},
            {12'h0, exp_addr(v, nrd)});
        held = mem_req_addr;
        if (poke && nrd == 0) begin
          req_valid = 1'b1; req_vaddr = ~v.va; req_asid = ~v.asid; root_base = '1;
          @(negedge clk);
          chk("R9 req_ready low while busy", {63'h0, req_ready}, 64'h0);
          req_valid = 1'b0;
        end
        for (int s = 0; s < int'(v.stall); s++) begin
          @(negedge clk);
          chk("R8 read held while stalled", {11'h0, mem_req_valid, mem_req_addr},
              {11'h0, 1'b1, held});
        end
        mem_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R8 no second read in flight", {63'h0, mem_req_valid}, 64'h0);
        for (int s = 0; s < int'(v.lat); s++) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = ent_of(v, nrd);
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        nrd++;
      end else begin
        @(negedge clk);
      end
    end
    chk($sformatf("R6 read count v%0d", vi), 64'(nrd), 64'(e_nrd));
    held = rsp_paddr;
    @(negedge clk);
    chk("R9 response held", {11'h0, rsp_valid, rsp_paddr}, {11'h0, 1'b1, held});
    chk($sformatf("R6 fault flag v%0d", vi), {63'h0, rsp_fault}, {63'h0, e_fault});
    chk($sformatf("R6 level v%0d", vi), {62'h0, rsp_level}, 64'(e_lvl));
    chk($sformatf("R6 vaddr v%0d", vi), {16'h0, rsp_vaddr}, {16'h0, v.va});
    chk($sformatf("R4 R5 paddr v%0d", vi), {12'h0, rsp_paddr}, {12'h0, e_pa});
    chk($sformatf("R4 frame v%0d", vi), {24'h0, rsp_frame}, {24'h0, e_pa[51:12]});
    chk($sformatf("R5 huge v%0d", vi), {63'h0, rsp_huge}, {63'h0, e_hg});
    chk($sformatf("R7 perms v%0d", vi), {62'h0, rsp_writable, rsp_user}, {62'h0, e_w, e_u});
    chk($sformatf("R10 asid v%0d", vi), {48'h0, rsp_asid}, {48'h0, v.asid});
    last_paddr = rsp_paddr;
    last_frame = rsp_frame;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 idle after response taken", {62'h0, req_ready, rsp_valid}, 64'h2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_asid = '0; root_base = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 reset outputs", {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);

    for (int i = 0; i < NVEC; i++) run_vec(i, 1'b0);

    // R4: worked example given as literals
    run_vec(0, 1'b0);
    chk("R4 example paddr", {12'h0, last_paddr}, 64'h1F2A_3123);
    chk("R4 example frame", {24'h0, last_frame}, 64'h1_F2A3);

    // R9: offer during busy walk is ignored
    run_vec(5, 1'b1);

    // R1: reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VECS[0].va; req_asid = 16'h0; root_base = VECS[0].root;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 walk started before reset", {63'h0, mem_req_valid}, 64'h1);
    do_reset();
    chk("R1 reset mid-walk", {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);
    run_vec(1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule